// File: doc/BRIEF.md
# Synchronous Clock Stop Controller

This block takes two free-running source clocks, a processor clock and a peripheral-bus clock, and produces gated copies of them. It also produces one ungated copy of the bus clock. Three active-low controls decide which copies toggle: a processor stop request, a bus stop request and a power-down request. Each control passes through a synchronizer in the domain of the clock it affects. The result then drives a gate whose enable is held in a latch that is open only while the source clock is LOW. Because of that latch, a gated output never shows a shortened high phase, neither when it stops nor when it starts again.

Power-down takes priority over both stop requests. While power-down is asserted, every output is held LOW, including the ungated bus copy. An active-low asynchronous reset clears every synchronizer, so all outputs start LOW and only begin toggling once the requests have been sampled through the pipeline.

The number of processor copies, the number of gated bus copies and the synchronizer depth are parameters.

Top module: `clk_stop_ctrl`

## Requirements
- R1: All `N_CPU` processor outputs carry identical values at every instant.
- R2: A gated output is either a full copy of its source clock's high phase or LOW for that whole high phase. The enable never changes while the source clock is HIGH.
- R3: With `SYNC_STAGES` = 2, a processor output is HIGH during the high phase that follows processor-clock rising edge n exactly when `cpu_stop_n` and `pwr_dn_n` were both HIGH at rising edge n-2. A change of request therefore shows up after 2 to 3 clock periods, both when stopping and when restarting.
- R4: All `N_PCI` gated bus outputs are identical. With `SYNC_STAGES` = 2, they are HIGH after bus-clock rising edge n exactly when `pci_stop_n` and `pwr_dn_n` were both HIGH at bus-clock rising edge n-2.
- R5: The free bus output ignores `pci_stop_n`. It is HIGH after bus-clock rising edge n exactly when `pwr_dn_n` was HIGH at rising edge n-2.
- R6: While `pwr_dn_n` has been LOW for two rising edges of a domain, every output of that domain is LOW whatever its stop request.
- R7: While `rst_n` is LOW, all outputs are LOW. After release, no output pulses before the third rising edge of its domain.
- R8: Every output is LOW throughout the LOW phase of its source clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_clk_src | input | 1 | Free-running processor source clock |
| pci_clk_src | input | 1 | Free-running bus source clock |
| cpu_stop_n | input | 1 | Processor stop request, LOW stops |
| pci_stop_n | input | 1 | Bus stop request, LOW stops the gated bus outputs |
| pwr_dn_n | input | 1 | Power-down request, LOW holds all outputs LOW |
| cpu_clk_o | output | N_CPU | Gated processor clock copies |
| pci_clk_o | output | N_PCI | Gated bus clock copies |
| pci_free_o | output | 1 | Bus clock copy gated only by power-down |

## Verification
The bench uses the default parameters: two processor copies, five gated bus copies and a two-stage synchronizer. With these values the latency is a fixed two edges, so the bench can predict the value of every output bit in every high phase from the request levels it recorded at earlier edges. The two source clocks run at unrelated periods, and the requests change at times that never coincide with a bus-clock edge. This exercises stops and restarts at every phase of the second domain. Each high phase is sampled early and late, and each low phase once, which exposes shortened pulses and gating that leaks into the LOW phase.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;
    localparam int DEF_SYNC_STAGES = 2;
    localparam int DEF_N_CPU       = 2;
    localparam int DEF_N_PCI       = 5;

    // decoded request pair of one domain after synchronization
    typedef struct packed {
        logic run_ok;
        logic pwr_ok;
    } req_pair_t;

    function automatic logic gated_enable(input req_pair_t r);
        return r.run_ok & r.pwr_ok;
    endfunction
endpackage

// File: rtl/cs_sync.sv
module cs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int TOP = STAGES - 1;

    typedef struct packed {
        logic [TOP:0] sh;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.sh = {st_q.sh[TOP-1:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.sh[TOP];
endmodule

// File: rtl/cs_domain_ctrl.sv
module cs_domain_ctrl
    import clk_stop_pkg::*;
#(
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_n,
    input  logic pwr_n,
    output logic en_gated,
    output logic en_free
);
    req_pair_t req_s;

    cs_sync #(.STAGES(SYNC_STAGES)) u_sync_stop (
        .clk(clk), .rst_n(rst_n), .d(stop_n), .q(req_s.run_ok)
    );

    cs_sync #(.STAGES(SYNC_STAGES)) u_sync_pwr (
        .clk(clk), .rst_n(rst_n), .d(pwr_n), .q(req_s.pwr_ok)
    );

    // power-down dominates: it clears both enables regardless of the stop request
    typedef struct packed {
        logic gated;
        logic free;
    } en_st_t;

    en_st_t en_d;

    always_comb begin
        en_d.free  = req_s.pwr_ok;
        en_d.gated = gated_enable(req_s);
    end

    assign en_gated = en_d.gated;
    assign en_free  = en_d.free;

    // edge counter since reset release, used only to bound $past below
    typedef struct packed {
        logic [1:0] cyc;
    } chk_st_t;

    chk_st_t chk_d, chk_q;

    always_comb begin
        chk_d = chk_q;
        if (chk_q.cyc != 2'd3) chk_d.cyc = chk_q.cyc + 2'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chk_q <= '0;
        else        chk_q <= chk_d;
    end

    generate
        if (SYNC_STAGES == 2) begin : g_lat_chk
            // R3
            req_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (chk_q.cyc >= 2'd2) |-> (en_gated == $past(stop_n && pwr_n, 2)));
            // R6
            pwr_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ((chk_q.cyc >= 2'd2) && !$past(pwr_n, 2)) |-> (!en_gated && !en_free));
            // R5
            free_ignores_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (chk_q.cyc >= 2'd2) |-> (en_free == $past(pwr_n, 2)));
        end
    endgenerate
endmodule

// File: rtl/cs_gate.sv
module cs_gate #(
    parameter int N = 1
) (
    input  logic         clk,
    input  logic         en,
    output logic [N-1:0] gclk
);
    logic en_l;

    // enable is only transparent while the source clock is LOW
    always_latch begin
        if (!clk) en_l = en;
    end

    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            assign gclk[i] = clk & en_l;
        end
    endgenerate
endmodule

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl
    import clk_stop_pkg::*;
#(
    parameter int N_CPU       = DEF_N_CPU,
    parameter int N_PCI       = DEF_N_PCI,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic             rst_n,
    input  logic             cpu_clk_src,
    input  logic             pci_clk_src,
    input  logic             cpu_stop_n,
    input  logic             pci_stop_n,
    input  logic             pwr_dn_n,
    output logic [N_CPU-1:0] cpu_clk_o,
    output logic [N_PCI-1:0] pci_clk_o,
    output logic             pci_free_o
);
    logic cpu_en_gated, cpu_en_pwr;
    logic pci_en_gated, pci_en_free;
    logic cpu_en;

    cs_domain_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_cpu_dom (
        .clk(cpu_clk_src), .rst_n(rst_n), .stop_n(cpu_stop_n), .pwr_n(pwr_dn_n),
        .en_gated(cpu_en_gated), .en_free(cpu_en_pwr)
    );

    cs_domain_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_pci_dom (
        .clk(pci_clk_src), .rst_n(rst_n), .stop_n(pci_stop_n), .pwr_n(pwr_dn_n),
        .en_gated(pci_en_gated), .en_free(pci_en_free)
    );

    assign cpu_en = cpu_en_gated & cpu_en_pwr;

    cs_gate #(.N(N_CPU)) u_cpu_gate (
        .clk(cpu_clk_src), .en(cpu_en), .gclk(cpu_clk_o)
    );

    cs_gate #(.N(N_PCI)) u_pci_gate (
        .clk(pci_clk_src), .en(pci_en_gated), .gclk(pci_clk_o)
    );

    cs_gate #(.N(1)) u_free_gate (
        .clk(pci_clk_src), .en(pci_en_free), .gclk(pci_free_o)
    );

    // R1
    cpu_lockstep_chk: assert property (@(negedge cpu_clk_src) disable iff (!rst_n)
        ((&cpu_clk_o) || !(|cpu_clk_o)));
    // R4
    pci_lockstep_chk: assert property (@(negedge pci_clk_src) disable iff (!rst_n)
        ((&pci_clk_o) || !(|pci_clk_o)));
endmodule

// File: tb/clk_stop_ctrl_tb.sv
`timescale 1ns/100ps
module clk_stop_ctrl_tb;
    localparam int N_CPU = 2;
    localparam int N_PCI = 5;

    logic rst_n = 1'b0;
    logic cpu_clk = 1'b0;
    logic pci_clk = 1'b0;
    logic cpu_stop_n = 1'b1;
    logic pci_stop_n = 1'b1;
    logic pwr_dn_n = 1'b1;
    logic [N_CPU-1:0] cpu_clk_o;
    logic [N_PCI-1:0] pci_clk_o;
    logic pci_free_o;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    clk_stop_ctrl #(.N_CPU(N_CPU), .N_PCI(N_PCI), .SYNC_STAGES(2)) u_dut (
        .rst_n(rst_n), .cpu_clk_src(cpu_clk), .pci_clk_src(pci_clk),
        .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .pwr_dn_n(pwr_dn_n),
        .cpu_clk_o(cpu_clk_o), .pci_clk_o(pci_clk_o), .pci_free_o(pci_free_o)
    );

    always #2.5 cpu_clk = ~cpu_clk;
    initial begin
        #0.3;
        forever #6 pci_clk = ~pci_clk;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
        end
    endtask

    function automatic int rep(input bit b, input int n);
        return b ? ((1 << n) - 1) : 0;
    endfunction

    function automatic string cause(input bit rst, input bit pwr_past, input bit dflt);
        if (!rst) return "R7";
        if (!pwr_past) return "R6";
        return dflt ? "R3" : "R4";
    endfunction

    // processor domain model: two-edge history of the combined request
    bit c_h1 = 0, c_h2 = 0, c_p1 = 1, c_p2 = 1;
    always @(posedge cpu_clk) begin
        bit e, pw;
        e = c_h2;
        pw = c_p2;
        if (!rst_n) begin
            c_h2 = 0; c_h1 = 0; e = 0;
        end else begin
            c_h2 = c_h1; c_h1 = cpu_stop_n & pwr_dn_n;
        end
        c_p2 = c_p1; c_p1 = pwr_dn_n;
        #0.4;
        chk(cpu_clk_o == rep(e, N_CPU), cause(rst_n, pw, 1), cpu_clk_o, rep(e, N_CPU));
        chk((&cpu_clk_o) || !(|cpu_clk_o), "R1", cpu_clk_o, rep(e, N_CPU));
        #1.7;
        chk(cpu_clk_o == rep(e, N_CPU), "R2", cpu_clk_o, rep(e, N_CPU));
        #1.4;
        chk(cpu_clk_o == 0, "R8", cpu_clk_o, 0);
    end

    // bus domain model: gated copies and free copy
    bit p_h1 = 0, p_h2 = 0, f_h1 = 0, f_h2 = 0;
    always @(posedge pci_clk) begin
        bit eg, ef;
        eg = p_h2;
        ef = f_h2;
        if (!rst_n) begin
            p_h1 = 0; p_h2 = 0; f_h1 = 0; f_h2 = 0; eg = 0; ef = 0;
        end else begin
            p_h2 = p_h1; p_h1 = pci_stop_n & pwr_dn_n;
            f_h2 = f_h1; f_h1 = pwr_dn_n;
        end
        #1;
        chk(pci_clk_o == rep(eg, N_PCI), cause(rst_n, ef, 0), pci_clk_o, rep(eg, N_PCI));
        chk(pci_free_o == ef, rst_n ? (ef ? "R5" : "R6") : "R7", pci_free_o, ef);
        #4.5;
        chk(pci_clk_o == rep(eg, N_PCI), "R2", pci_clk_o, rep(eg, N_PCI));
        chk(pci_free_o == ef, "R5", pci_free_o, ef);
        #2.5;
        chk(pci_clk_o == 0 && pci_free_o == 0, "R8", {pci_free_o, pci_clk_o}, 0);
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge cpu_clk);
            #2;
        end
    endtask

    initial begin
        int seed;
        seed = 32'h5EED_0C1C;
        void'($urandom(seed));
        #101.1;
        // R7: outputs low during and just after reset
        chk(cpu_clk_o == 0 && pci_clk_o == 0 && pci_free_o == 0, "R7",
            {pci_free_o, pci_clk_o, cpu_clk_o}, 0);
        rst_n = 1'b1;
        cyc(30);
        // R3 stop then restart of the processor copies
        cpu_stop_n = 1'b0; cyc(20);
        cpu_stop_n = 1'b1; cyc(20);
        // R4/R5 bus stop, free copy keeps running
        pci_stop_n = 1'b0; cyc(40);
        pci_stop_n = 1'b1; cyc(30);
        // R6 power-down overrides released stops and active stops
        pwr_dn_n = 1'b0; cyc(60);
        cpu_stop_n = 1'b0; pci_stop_n = 1'b0; cyc(10);
        pwr_dn_n = 1'b1; cyc(20);
        cpu_stop_n = 1'b1; pci_stop_n = 1'b1; cyc(30);
        // single-cycle request pulses
        cpu_stop_n = 1'b0; cyc(1); cpu_stop_n = 1'b1; cyc(10);
        // random phase
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(15, 0) == 0) cpu_stop_n = ~cpu_stop_n;
            if ($urandom_range(39, 0) == 0) pci_stop_n = ~pci_stop_n;
            if ($urandom_range(79, 0) == 0) pwr_dn_n = ~pwr_dn_n;
            cyc(1);
        end
        cyc(10);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #500us;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired at %0t: actual running expected done", $time);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule